// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a clocked single-port static RAM. Reads and writes may follow each other on every clock with no idle cycle between them. The address, chip select, read/write select, byte enables, advance control and write data are all taken on the rising clock edge. The output enable and the burst-order select are not registered, so they act within the cycle in which they are applied.

A static mode input picks one of two timings:
- **Flow-through:** read data comes straight from the array during the cycle after the command edge. Write data is taken on the next edge.
- **Pipelined:** read data passes through an output register and appears one edge later. Write data is taken two edges after the command.

In both modes the array write is held back until its data arrives. In pipelined mode a read that lands while a write is still waiting for its data is served from that waiting write. This keeps read-after-write ordering without stalling the bus.

A 2-bit beat counter builds the low address bits of the follow-on beats of a burst. The beat order is either linear or interleaved. The depth and the word shape are parameters; the defaults are 256 words of four 9-bit bytes.

Top module: `nbt_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released until a read beat presents data, `dout_en` is 0 and `dout` is 0.
- R2: In flow-through mode (`pipe_mode`=0), a read command taken on edge N presents the word on `dout` in the cycle between edges N and N+1.
- R3: In pipelined mode (`pipe_mode`=1), a read command taken on edge N presents the word in the cycle between edges N+1 and N+2.
- R4: In flow-through mode, the data of a write command taken on edge N is the `din` value on edge N+1. `din` on any other edge is not stored.
- R5: In pipelined mode, the data of a write command taken on edge N is the `din` value on edge N+2. `din` on any other edge is not stored.
- R6: Bit b of `byte_en` selects byte lane b, which is bits b*BYTE_W up to b*BYTE_W+BYTE_W-1. Lanes whose bit is 0 keep their old contents. The enables are taken with each beat.
- R7: With `adv`=0 and `sel`=1 a new address is loaded as beat 0. Each following edge with `adv`=1 steps the beat count by 1 modulo 4. The address bits above bit 1 stay those of the loaded address. With `order_ilv`=0 the low two bits are (start + beat) mod 4.
- R8: With `order_ilv`=1 the low two bits of a burst beat are the start offset XOR the beat count.
- R9: An `adv`=1 beat repeats the read or write type of the loaded command, whatever `we` and `sel` are. After a deselect (`adv`=0, `sel`=0) or a reset, `adv`=1 issues no access.
- R10: In pipelined mode, a read issued on the edge after a write to the same word returns the new data in the enabled lanes merged over the stored word.
- R11: `dout_en` is high only while `oe` is 1 and a read beat is presenting. `oe` acts in the same cycle. `dout` is 0 whenever `dout_en` is 0.
- R12: In pipelined mode, a read taken on edge N still presents its data after edge N+1 even when a deselect is taken on edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | 0 = flow-through timing, 1 = pipelined timing |
| sel | input | 1 | Chip select for a load command |
| we | input | 1 | 1 = write, 0 = read, for a load command |
| adv | input | 1 | 1 = step the burst, 0 = load a new address or deselect |
| addr | input | ADDR_W | Word address of a load command |
| byte_en | input | BYTES | Per-lane write enables |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (not registered) |
| oe | input | 1 | Output enable (not registered) |
| din | input | BYTES*BYTE_W | Write data bus |
| dout | output | BYTES*BYTE_W | Read data bus |
| dout_en | output | 1 | Bus drive enable; low means high impedance |

## Verification
The assertions assume that `pipe_mode` and `order_ilv` hold steady for the whole of a command's life, from the command edge to the edge that commits its data. Those inputs feed the address and latency paths without a register. The stimulus therefore changes them only after three deselected cycles, by which time no beat is in flight. Reads go only to words that have already been written in full, so every expected value is defined. Random traffic keeps its bursts inside one pre-filled aligned region.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int BEAT_W = 2;

    // low address bits of a burst beat: linear adds, interleaved XORs
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              xor_order
    );
        return xor_order ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/nbt_burst_seq.sv
module nbt_burst_seq
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  byte_en,
    input  logic              order_ilv,
    output logic              cmd_valid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BYTES-1:0]  cmd_be
);

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic [BYTES-1:0]  be;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.be = byte_en;
        if (!adv) begin
            st_d.valid = sel;
            if (sel) begin
                st_d.wr   = we;
                st_d.base = addr;
                st_d.beat = '0;
            end
        end else if (st_q.valid) begin
            st_d.beat = st_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = st_q.valid;
    assign cmd_wr    = st_q.wr;
    assign cmd_be    = st_q.be;
    assign cmd_addr  = {st_q.base[ADDR_W-1:BEAT_W],
                        beat_offset(st_q.base[BEAT_W-1:0], st_q.beat, order_ilv)};

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && st_q.valid |=> cmd_valid && (st_q.beat == $past(st_q.beat) + BEAT_W'(1)));

    // R9
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !st_q.valid |=> !cmd_valid);

endmodule

// File: rtl/nbt_store.sv
module nbt_store #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTES-1:0]          wr_be,
    input  logic [BYTES*BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTES*BYTE_W-1:0]   rd_data
);

    localparam int DATA_W = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // storage array: written per lane, read without a register
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    sel,
    input  logic                    we,
    input  logic                    adv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        byte_en,
    input  logic                    order_ilv,
    input  logic                    oe,
    input  logic [BYTES*BYTE_W-1:0] din,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = BYTES * BYTE_W;

    typedef struct packed {
        logic              late_vld;
        logic [ADDR_W-1:0] late_addr;
        logic [BYTES-1:0]  late_be;
        logic              rd_vld;
        logic [DATA_W-1:0] rd_data;
    } pipe_t;

    pipe_t pl_d, pl_q;

    logic              cmd_valid, cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [BYTES-1:0]  cmd_be;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTES-1:0]  wr_be;
    logic [DATA_W-1:0] arr_data, merged;
    logic              fwd_hit, rd_beat, present;

    nbt_burst_seq #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .we        (we),
        .adv       (adv),
        .addr      (addr),
        .byte_en   (byte_en),
        .order_ilv (order_ilv),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be)
    );

    nbt_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (din),
        .rd_addr (cmd_addr),
        .rd_data (arr_data)
    );

    assign rd_beat = cmd_valid && !cmd_wr;
    assign fwd_hit = pipe_mode && pl_q.late_vld && rd_beat && (pl_q.late_addr == cmd_addr);

    // per-lane bypass of the write still waiting for its data
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && pl_q.late_be[b])
                                            ? din[b*BYTE_W +: BYTE_W]
                                            : arr_data[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        pl_d           = pl_q;
        pl_d.late_vld  = pipe_mode && cmd_valid && cmd_wr;
        pl_d.late_addr = cmd_addr;
        pl_d.late_be   = cmd_be;
        pl_d.rd_vld    = rd_beat;
        pl_d.rd_data   = merged;

        if (pipe_mode) begin
            wr_en   = pl_q.late_vld;
            wr_addr = pl_q.late_addr;
            wr_be   = pl_q.late_be;
        end else begin
            wr_en   = cmd_valid && cmd_wr;
            wr_addr = cmd_addr;
            wr_be   = cmd_be;
        end

        present = pipe_mode ? pl_q.rd_vld : rd_beat;
        dout_en = oe && present;
        if (!dout_en)       dout = '0;
        else if (pipe_mode) dout = pl_q.rd_data;
        else                dout = arr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    // R5
    late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_mode && $past(pipe_mode) && $past(cmd_valid && cmd_wr)
        |-> wr_en && (wr_addr == $past(cmd_addr)));

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dout_en && (dout == '0));

    // R12
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_mode && $past(pipe_mode) && $past(cmd_valid && !cmd_wr) && oe |-> dout_en);

endmodule

// File: tb/nbt_sram_test.sv
module nbt_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          sel = 1'b0, we = 1'b0, adv = 1'b0, order_ilv = 1'b0, oe = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] byte_en = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    nbt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel(sel), .we(we), .adv(adv),
        .addr(addr), .byte_en(byte_en), .order_ilv(order_ilv), .oe(oe), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [DW-1:0] data;
        string       tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] model [int];
    logic [DW-1:0] sched [int];
    int            vectors = 0;
    int            errors = 0;
    bit            done = 1'b0;

    bit            b_act = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_beat = '0;

    function automatic logic [AW-1:0] beat_addr();
        logic [1:0] lo;
        lo = order_ilv ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat);
        return {b_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] junk(input int c);
        return DW'(36'h5A5A5A5A5) ^ DW'(c * 7919);
    endfunction

    // driver: one bus cycle, expectations pushed into the scoreboard
    task automatic step(input bit s, input bit w, input bit a, input logic [AW-1:0] ad,
                        input logic [NB-1:0] be, input logic [DW-1:0] d, input bit o,
                        input string tag);
        int c, p, lat;
        bit issue;
        logic [AW-1:0] ea;
        logic [DW-1:0] nv;
        exp_t e;
        @(negedge clk);
        #1;
        c = cyc;
        p = c + 1;
        lat = pipe_mode ? 2 : 1;
        issue = 1'b0;
        if (!a) begin
            if (s) begin
                b_act = 1'b1; b_wr = w; b_base = ad; b_beat = '0; issue = 1'b1;
            end else begin
                b_act = 1'b0;
            end
        end else if (b_act) begin
            b_beat = b_beat + 2'd1;
            issue = 1'b1;
        end
        if (issue) begin
            ea = beat_addr();
            if (b_wr) begin
                nv = model.exists(int'(ea)) ? model[int'(ea)] : '0;
                for (int b = 0; b < NB; b++) if (be[b]) nv[b*BW +: BW] = d[b*BW +: BW];
                model[int'(ea)] = nv;
                sched[p + lat - 1] = d;
            end else begin
                e.due = p + lat - 1;
                e.data = model[int'(ea)];
                e.tag = tag;
                sb.push_back(e);
            end
        end
        sel = s; we = w; adv = a; addr = ad; byte_en = be; oe = o;
        din = sched.exists(c) ? sched[c] : junk(c);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, "R11");
    endtask

    task automatic set_mode(input bit m);
        idle(3);
        pipe_mode = m;
    endtask

    task automatic set_order(input bit v);
        idle(3);
        order_ilv = v;
    endtask

    task automatic rand_phase(input int n);
        for (int i = 0; i < n; i++) begin
            int r;
            bit s, a;
            r = int'($urandom());
            a = (r % 4) == 0;
            s = (r % 7) != 0;
            step(s, r[8], a, AW'(8'h40 + (r[12:10] & 3'h7)), NB'(r[16:13]),
                 DW'({$urandom(), $urandom()}), (r[18:17] != 2'b00), "R10");
        end
    endtask

    // monitor: pops the scoreboard as results appear
    initial begin
        forever begin
            exp_t e;
            logic [DW:0] act, expv;
            string tag;
            @(negedge clk);
            if (done) break;
            while (sb.size() > 0 && sb[0].due < cyc) begin
                e = sb.pop_front();
                errors++; vectors++;
                $display("FAIL %s: actual no beat at cycle %0d, expected beat due %0d", e.tag, cyc, e.due);
            end
            if (sb.size() > 0 && sb[0].due == cyc) begin
                e = sb.pop_front();
                tag = e.tag;
                expv = oe ? {1'b1, e.data} : '0;
            end else begin
                tag = (cyc <= 6) ? "R1" : "R11";
                expv = '0;
            end
            act = {dout_en, dout};
            vectors++;
            if (act !== expv) begin
                errors++;
                $display("FAIL %s: cycle %0d actual en=%0b data=%h expected en=%0b data=%h",
                         tag, cyc, act[DW], act[DW-1:0], expv[DW], expv[DW-1:0]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // flow-through: linear write burst with adv repeating the write (R4, R7, R9)
        step(1, 1, 0, 8'h10, 4'hF, 36'h111111111, 1, "R4");
        step(0, 0, 1, 8'h00, 4'hF, 36'h222222222, 1, "R9");
        step(0, 0, 1, 8'h00, 4'hF, 36'h333333333, 1, "R7");
        step(0, 0, 1, 8'h00, 4'hF, 36'h444444444, 1, "R7");
        idle(1);
        // linear read burst from offset 2 with we high on adv beats (R2, R7, R9)
        step(1, 0, 0, 8'h12, 4'h0, '0, 1, "R2");
        step(0, 1, 1, 8'h00, 4'hF, '0, 1, "R9");
        step(0, 1, 1, 8'h00, 4'hF, '0, 1, "R7");
        step(0, 1, 1, 8'h00, 4'hF, '0, 1, "R7");
        idle(2);
        // lanes 0 and 2 only (R6)
        step(1, 1, 0, 8'h11, 4'b0101, 36'hABCDEF012, 1, "R6");
        step(1, 0, 0, 8'h11, 4'h0, '0, 1, "R6");
        // alternating write/read every cycle (R2, R4)
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 0, AW'(8'h18 + i), 4'hF, DW'(36'h0F0F0F000 + i * 37), 1, "R4");
            step(1, 0, 0, AW'(8'h18 + i), 4'h0, '0, 1, "R2");
        end
        // output enable low on a read (R11)
        step(1, 0, 0, 8'h10, 4'h0, '0, 0, "R11");
        step(1, 0, 0, 8'h1A, 4'h0, '0, 1, "R11");
        // deselect, then adv with no burst must not write (R9)
        step(1, 1, 0, 8'h1C, 4'hF, 36'h9876543AB, 1, "R4");
        step(0, 0, 0, 8'h00, 4'h0, '0, 1, "R9");
        step(0, 1, 1, 8'h1D, 4'hF, '0, 1, "R9");
        step(1, 0, 0, 8'h1C, 4'h0, '0, 1, "R9");
        step(1, 0, 0, 8'h1D, 4'h0, '0, 1, "R9");

        // interleaved order (R8)
        set_order(1);
        step(1, 0, 0, 8'h13, 4'h0, '0, 1, "R8");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 8'h00, 4'h0, '0, 1, "R8");
        step(1, 1, 0, 8'h25, 4'hF, 36'h0000000A1, 1, "R8");
        step(0, 0, 1, 8'h00, 4'hF, 36'h0000000B2, 1, "R8");
        step(0, 0, 1, 8'h00, 4'hF, 36'h0000000C3, 1, "R8");
        step(0, 0, 1, 8'h00, 4'hF, 36'h0000000D4, 1, "R8");
        step(1, 0, 0, 8'h26, 4'h0, '0, 1, "R8");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 8'h00, 4'h0, '0, 1, "R8");
        set_order(0);

        // pipelined timing
        set_mode(1);
        step(1, 1, 0, 8'h30, 4'hF, 36'h123456789, 1, "R5");
        step(1, 0, 0, 8'h30, 4'h0, '0, 1, "R10");
        step(1, 1, 0, 8'h30, 4'b1100, 36'hFEDCBA987, 1, "R6");
        step(1, 0, 0, 8'h30, 4'h0, '0, 1, "R10");
        step(1, 0, 0, 8'h30, 4'h0, '0, 1, "R3");
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 0, AW'(8'h38 + i), 4'hF, DW'(36'h777000000 + i * 101), 1, "R5");
            step(1, 0, 0, AW'(8'h38 + (i > 0 ? i - 1 : 0)), 4'h0, '0, (i != 3), "R3");
        end
        // read followed by a deselect still drains (R12)
        step(1, 0, 0, 8'h30, 4'h0, '0, 1, "R12");
        step(0, 0, 0, 8'h00, 4'h0, '0, 1, "R12");
        idle(1);
        step(1, 1, 0, 8'h2D, 4'hF, 36'h00000F001, 1, "R5");
        step(0, 0, 1, 8'h00, 4'hF, 36'h00000F002, 1, "R5");
        step(0, 0, 1, 8'h00, 4'hF, 36'h00000F003, 1, "R5");
        step(0, 0, 1, 8'h00, 4'hF, 36'h00000F004, 1, "R5");
        step(1, 0, 0, 8'h2D, 4'h0, '0, 1, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 8'h00, 4'h0, '0, 1, "R7");

        // random mixed traffic in both modes over a pre-filled region (R10)
        for (int i = 0; i < 8; i++)
            step(1, 1, 0, AW'(8'h40 + i), 4'hF, DW'({$urandom(), $urandom()}), 1, "R5");
        rand_phase(300);
        set_mode(0);
        rand_phase(300);
        idle(4);

        done = 1'b1;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule